// File: doc/BRIEF.md
# Thresholded Performance Event Counter

This block is one performance-monitor counter. On every cycle it may receive a sample: a small count of how many events happened in that cycle, plus the privilege level the core was running at (user, kernel or hypervisor). The counter adds that sample to its running total only if three things hold. Counting must be enabled. The privilege level must not be filtered out. The sample must pass a programmable threshold comparison. In a count-by-one mode, a passing sample adds exactly one instead of its value.

Configuration goes through a small synchronous write port with three registers:

| Address | Register |
|---|---|
| 0 | control |
| 1 | counter load |
| 2 | overflow clear |

A threshold is checked against a fixed capability limit when it is written. A threshold above the limit is refused and an error flag is raised. The counter runs either 32 or 64 bits wide. A carry out of the active width wraps the total and sets a sticky overflow flag.

Top module: `thr_event_counter`

## Requirements
- R1: After a synchronous active-high reset, `count_q`, `ovf_q` and `thr_reject_q` are 0. All control fields are also 0, so counting is disabled and the threshold is 0.
- R2: When the accepted threshold is 0, every counted sample adds its raw `ev_count`. The compare function and count-by-one are ignored in this case.
- R3: The compare function sits in control bits [7:6]. With a nonzero threshold in control bits [27:16], the compare codes mean:
  - 0: passes when the count is not equal to the threshold.
  - 1: passes when the count equals the threshold.
  - 2: passes when the count is greater than or equal to the threshold.
  - 3: passes when the count is less than the threshold.
- R4: A passing sample adds `ev_count`, or exactly 1 when count-by-one (control bit 8) is set. A failing sample adds 0.
- R5: A control write whose threshold is nonzero and greater than `CAP_MAX` keeps the previous threshold and sets `thr_reject_q`. The write's other control fields still take effect. An accepted control write clears `thr_reject_q`. `thr_cap` always reports `CAP_MAX`.
- R6: With `CAP_MAX` = 0, every nonzero threshold is refused, so samples are always added raw.
- R7: Control bit 1 selects the counter width.
  - When bit 1 is 0 (32-bit mode), an addition wraps modulo 2^32 and the upper 32 bits read 0 after it.
  - When bit 1 is 1 (64-bit mode), an addition wraps modulo 2^64.
  - In either mode, a carry out of the active width sets `ovf_q`.
- R8: `ovf_q` is sticky. It is cleared only by a write to address 2 with data bit 0 set. A new carry in the same cycle as that write wins, and the flag stays set.
- R9: Privilege-level filtering uses `ev_level` codes 0 = user, 1 = kernel, 2 or 3 = hypervisor.
  - Control bit 2 blocks level 0.
  - Control bit 3 blocks level 1. It also blocks level 2 when control bit 5 (kernel-runs-at-hypervisor mode) is set.
  - Control bit 4 blocks level 2 only when bit 5 is clear. It has no effect when bit 5 is set.
- R10: Nothing is added when control bit 0 (enable) is 0 or when `ev_valid` is 0.
- R11: A write to address 1 loads the counter in the same cycle and overrides any increment in that cycle. In 32-bit mode the upper 32 bits of the loaded value are cleared.
- R12: A sample presented in cycle N shows in `count_q` and `ovf_q` right after edge N. A control write in cycle N governs samples starting from cycle N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 counter load, 2 overflow clear, 3 ignored |
| wr_data | input | CNT_W | Write data |
| ev_valid | input | 1 | Qualifies this cycle's sample |
| ev_count | input | EV_W | Number of events in this cycle |
| ev_level | input | 2 | Privilege level of this cycle's sample |
| count_q | output | CNT_W | Counter value |
| ovf_q | output | 1 | Sticky overflow flag |
| thr_reject_q | output | 1 | Last control write had its threshold refused |
| thr_cap | output | 12 | Largest threshold that can be programmed |

## Verification
Every result is due one edge after its stimulus. A counted sample, a counter load, an overflow clear and a threshold refusal each appear right after the edge that samples them. A control write changes counting only from the following cycle. The bench drives inputs 1 ns after a rising edge and checks outputs 1 ns after the next rising edge, so each check sees exactly one register update. One directed case places a control write and a sample in the same cycle to pin down the one-cycle delay of configuration.

// File: rtl/thr_cnt_pkg.sv
package thr_cnt_pkg;

  localparam int THR_W = 12;

  typedef enum logic [1:0] {
    CMP_NE = 2'd0,
    CMP_EQ = 2'd1,
    CMP_GE = 2'd2,
    CMP_LT = 2'd3
  } cmp_e;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_LOAD = 2'd1,
    ADDR_OVFC = 2'd2,
    ADDR_NONE = 2'd3
  } addr_e;

  typedef struct packed {
    logic             en;
    logic             wide;
    logic             x_user;
    logic             x_kern;
    logic             x_hyp;
    logic             kern_hyp;
    cmp_e             cmp;
    logic             by_one;
    logic [THR_W-1:0] thr;
  } cfg_t;

  // Threshold compare on zero-extended operands.
  function automatic logic cmp_pass(cmp_e f, logic [THR_W-1:0] a, logic [THR_W-1:0] t);
    case (f)
      CMP_NE:  return a != t;
      CMP_EQ:  return a == t;
      CMP_GE:  return a >= t;
      default: return a < t;
    endcase
  endfunction

  // Privilege-level exclusion; codes 2 and 3 are both the hypervisor level.
  function automatic logic level_blocked(cfg_t c, logic [1:0] lvl);
    case (lvl)
      2'd0:    return c.x_user;
      2'd1:    return c.x_kern;
      default: return c.kern_hyp ? c.x_kern : c.x_hyp;
    endcase
  endfunction

endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
  import thr_cnt_pkg::*;
#(
  parameter int CAP_MAX = 255
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_wr,
  input  logic [27:0] ctrl_bits,
  output cfg_t        cfg,
  output logic        reject_q
);

  logic [THR_W-1:0] thr_new;
  logic             thr_bad;

  assign thr_new = ctrl_bits[27:16];
  // Threshold 0 is always legal; a nonzero value must not exceed the capability.
  assign thr_bad = (thr_new != '0) && (32'(thr_new) > 32'(CAP_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      reject_q <= 1'b0;
    end else if (ctrl_wr) begin
      cfg.en       <= ctrl_bits[0];
      cfg.wide     <= ctrl_bits[1];
      cfg.x_user   <= ctrl_bits[2];
      cfg.x_kern   <= ctrl_bits[3];
      cfg.x_hyp    <= ctrl_bits[4];
      cfg.kern_hyp <= ctrl_bits[5];
      cfg.cmp      <= cmp_e'(ctrl_bits[7:6]);
      cfg.by_one   <= ctrl_bits[8];
      if (!thr_bad) cfg.thr <= thr_new;
      reject_q     <= thr_bad;
    end
  end

endmodule

// File: rtl/thr_gate.sv
module thr_gate
  import thr_cnt_pkg::*;
#(
  parameter int EV_W = 8
) (
  input  cfg_t            cfg,
  input  logic            ev_valid,
  input  logic [EV_W-1:0] ev_count,
  input  logic [1:0]      ev_level,
  output logic            lvl_block,
  output logic            cmp_ok,
  output logic [EV_W-1:0] inc_amt
);

  localparam int PAD_W = THR_W - EV_W;

  logic [THR_W-1:0] ev_ext;

  assign ev_ext    = {{PAD_W{1'b0}}, ev_count};
  assign lvl_block = level_blocked(cfg, ev_level);
  assign cmp_ok    = (cfg.thr == '0) || cmp_pass(cfg.cmp, ev_ext, cfg.thr);

  always_comb begin
    inc_amt = '0;
    if (cfg.en && ev_valid && !lvl_block && cmp_ok) begin
      if (cfg.thr != '0 && cfg.by_one) inc_amt = EV_W'(1);
      else                             inc_amt = ev_count;
    end
  end

endmodule

// File: rtl/thr_accum.sv
module thr_accum #(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 32,
  parameter int EV_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide,
  input  logic [EV_W-1:0]  inc_amt,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q,
  output logic             wrap_evt
);

  localparam int HI_W = CNT_W - NARROW_W;

  logic [CNT_W:0]    sum_w;
  logic [NARROW_W:0] sum_n;
  logic [CNT_W-1:0]  next_cnt;
  logic              add_any;

  assign add_any = (inc_amt != '0);
  assign sum_w   = {1'b0, count_q} + {{(CNT_W+1-EV_W){1'b0}}, inc_amt};
  assign sum_n   = {1'b0, count_q[NARROW_W-1:0]} + {{(NARROW_W+1-EV_W){1'b0}}, inc_amt};

  always_comb begin
    if (wide) begin
      next_cnt = sum_w[CNT_W-1:0];
      wrap_evt = add_any && !load_en && sum_w[CNT_W];
    end else begin
      next_cnt = {{HI_W{1'b0}}, sum_n[NARROW_W-1:0]};
      wrap_evt = add_any && !load_en && sum_n[NARROW_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (load_en)
        count_q <= wide ? load_val : {{HI_W{1'b0}}, load_val[NARROW_W-1:0]};
      else if (add_any)
        count_q <= next_cnt;
      if (wrap_evt)     ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

endmodule

// File: rtl/thr_event_counter.sv
module thr_event_counter
  import thr_cnt_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int EV_W    = 8,
  parameter int CAP_MAX = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ev_valid,
  input  logic [EV_W-1:0]  ev_count,
  input  logic [1:0]       ev_level,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q,
  output logic             thr_reject_q,
  output logic [11:0]      thr_cap
);

  localparam int NARROW_W = 32;

  cfg_t            cfg;
  logic            ctrl_wr;
  logic            load_wr;
  logic            ovf_clr;
  logic            lvl_block;
  logic            cmp_ok;
  logic [EV_W-1:0] inc_amt;
  logic            wrap_evt;

  assign ctrl_wr = wr_en && (addr_e'(wr_addr) == ADDR_CTRL);
  assign load_wr = wr_en && (addr_e'(wr_addr) == ADDR_LOAD);
  assign ovf_clr = wr_en && (addr_e'(wr_addr) == ADDR_OVFC) && wr_data[0];
  assign thr_cap = 12'(CAP_MAX);

  thr_cfg_regs #(.CAP_MAX(CAP_MAX)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_bits (wr_data[27:0]),
    .cfg       (cfg),
    .reject_q  (thr_reject_q)
  );

  thr_gate #(.EV_W(EV_W)) u_gate (
    .cfg       (cfg),
    .ev_valid  (ev_valid),
    .ev_count  (ev_count),
    .ev_level  (ev_level),
    .lvl_block (lvl_block),
    .cmp_ok    (cmp_ok),
    .inc_amt   (inc_amt)
  );

  thr_accum #(.CNT_W(CNT_W), .NARROW_W(NARROW_W), .EV_W(EV_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .wide     (cfg.wide),
    .inc_amt  (inc_amt),
    .load_en  (load_wr),
    .load_val (wr_data),
    .ovf_clr  (ovf_clr),
    .count_q  (count_q),
    .ovf_q    (ovf_q),
    .wrap_evt (wrap_evt)
  );

endmodule

// File: rtl/thr_event_counter_chk.sv
module thr_event_counter_chk
  import thr_cnt_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int EV_W    = 8,
  parameter int CAP_MAX = 255
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             ev_valid,
  input logic [1:0]       ev_level,
  input logic [CNT_W-1:0] count_q,
  input logic             ovf_q,
  input logic             thr_reject_q,
  input cfg_t             cfg,
  input logic [EV_W-1:0]  inc_amt
);

  logic load_w;
  logic ctrl_w;

  assign load_w = wr_en && wr_addr == 2'd1;
  assign ctrl_w = wr_en && wr_addr == 2'd0;

  a_r5_thr_within_cap: assert property (@(posedge clk) disable iff (rst)
    32'(cfg.thr) <= 32'(CAP_MAX));

  a_r5_reject_keeps_thr: assert property (@(posedge clk) disable iff (rst)
    (ctrl_w && wr_data[27:16] != 12'd0 && 32'(wr_data[27:16]) > 32'(CAP_MAX))
      |=> (thr_reject_q && $stable(cfg.thr)));

  a_r10_disabled_holds: assert property (@(posedge clk) disable iff (rst)
    (!cfg.en && !load_w) |=> $stable(count_q));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> ovf_q);

  a_r11_load_wins: assert property (@(posedge clk) disable iff (rst)
    (load_w && cfg.wide && !ctrl_w) |=> count_q == $past(wr_data));

  a_r9_user_blocked: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_level == 2'd0 && cfg.x_user && !load_w) |=> $stable(count_q));

  a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (!cfg.wide && inc_amt != '0 && !load_w) |=> count_q[CNT_W-1:32] == '0);

endmodule

bind thr_event_counter thr_event_counter_chk #(
  .CNT_W(CNT_W), .EV_W(EV_W), .CAP_MAX(CAP_MAX)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .ev_valid     (ev_valid),
  .ev_level     (ev_level),
  .count_q      (count_q),
  .ovf_q        (ovf_q),
  .thr_reject_q (thr_reject_q),
  .cfg          (cfg),
  .inc_amt      (inc_amt)
);

// File: tb/tb_thr_event_counter.sv
module tb_thr_event_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [63:0] wr_data = 64'd0;
  logic        ev_valid = 1'b0;
  logic [7:0]  ev_count = 8'd0;
  logic [1:0]  ev_level = 2'd0;
  logic [63:0] count_q, count_nc;
  logic        ovf_q, ovf_nc, rej_q, rej_nc;
  logic [11:0] cap_q, cap_nc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thr_event_counter dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_valid(ev_valid), .ev_count(ev_count), .ev_level(ev_level),
    .count_q(count_q), .ovf_q(ovf_q), .thr_reject_q(rej_q), .thr_cap(cap_q));

  thr_event_counter #(.CAP_MAX(0)) dut_nc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_valid(ev_valid), .ev_count(ev_count), .ev_level(ev_level),
    .count_q(count_nc), .ovf_q(ovf_nc), .thr_reject_q(rej_nc), .thr_cap(cap_nc));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] mk(bit en, bit wide, bit xu, bit xk, bit xh,
                                     bit kh, int cmp, bit one, int thr);
    logic [63:0] w = 64'd0;
    w[0] = en; w[1] = wide; w[2] = xu; w[3] = xk; w[4] = xh; w[5] = kh;
    w[7:6] = cmp[1:0]; w[8] = one; w[27:16] = thr[11:0];
    return w;
  endfunction

  // Bench model of one sample's contribution under an accepted threshold.
  function automatic int model_add(int cmp, bit one, int thr, int v);
    bit ok;
    if (thr == 0) return v;
    ok = (cmp == 0) ? (v != thr) : (cmp == 1) ? (v == thr) :
         (cmp == 2) ? !(v < thr) : (thr > v);
    if (!ok) return 0;
    return one ? 1 : v;
  endfunction

  task automatic wr(int a, logic [63:0] d);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic ev(int v, int lvl);
    ev_valid = 1'b1; ev_count = v[7:0]; ev_level = lvl[1:0];
    step();
    ev_valid = 1'b0;
  endtask

  task automatic clean();
    wr(0, 64'd0);
    wr(1, 64'd0);
    wr(2, 64'd1);
  endtask

  task automatic t_reset();
    chk("R1 count", count_q, 0);
    chk("R1 ovf", {63'd0, ovf_q}, 0);
    chk("R1 reject", {63'd0, rej_q}, 0);
    ev(9, 0);
    chk("R1 disabled after reset", count_q, 0);
    chk("R5 cap value", {52'd0, cap_q}, 255);
  endtask

  task automatic t_raw();
    clean();
    wr(0, mk(1, 0, 0, 0, 0, 0, 1, 1, 0));
    ev(5, 0); ev(7, 1); ev(0, 2);
    chk("R2 raw sum with threshold 0", count_q, 12);
  endtask

  task automatic t_compare();
    for (int c = 0; c < 4; c++) begin
      int e = 0;
      clean();
      wr(0, mk(1, 0, 0, 0, 0, 0, c, 0, 4));
      for (int v = 3; v <= 5; v++) begin
        ev(v, 0);
        e += model_add(c, 0, 4, v);
      end
      chk($sformatf("R3 compare code %0d", c), count_q, 64'(e));
    end
    clean();
    wr(0, mk(1, 0, 0, 0, 0, 0, 2, 1, 4));
    ev(3, 0); ev(4, 0); ev(200, 0);
    chk("R4 count-by-one", count_q, 2);
  endtask

  task automatic t_cap();
    clean();
    wr(0, mk(1, 0, 0, 0, 0, 0, 1, 0, 4));
    chk("R5 accepted", {63'd0, rej_q}, 0);
    wr(0, mk(1, 0, 0, 0, 0, 0, 1, 1, 256));
    chk("R5 refused flag", {63'd0, rej_q}, 1);
    ev(4, 0); ev(9, 0);
    chk("R5 old threshold kept, by-one applied", count_q, 1);
    wr(0, mk(1, 0, 0, 0, 0, 0, 1, 0, 255));
    chk("R5 limit accepted", {63'd0, rej_q}, 0);
    ev(255, 0);
    chk("R5 threshold 255 used", count_q, 256);
  endtask

  task automatic t_nocap();
    clean();
    chk("R6 cap value", {52'd0, cap_nc}, 0);
    wr(0, mk(1, 0, 0, 0, 0, 0, 1, 1, 1));
    chk("R6 refused", {63'd0, rej_nc}, 1);
    ev(6, 0);
    chk("R6 raw sum", count_nc, 6);
  endtask

  task automatic t_wrap();
    clean();
    wr(0, mk(1, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(1, 64'hABCD_0000_FFFF_FFFE);
    chk("R11 narrow load clears upper", count_q, 64'hFFFF_FFFE);
    ev(3, 0);
    chk("R7 narrow wrap", count_q, 1);
    chk("R7 narrow ovf", {63'd0, ovf_q}, 1);
    ev(2, 0);
    chk("R8 sticky", {63'd0, ovf_q}, 1);
    wr(2, 64'd0);
    chk("R8 write without bit0", {63'd0, ovf_q}, 1);
    wr(2, 64'd1);
    chk("R8 cleared", {63'd0, ovf_q}, 0);
    wr(0, mk(1, 1, 0, 0, 0, 0, 0, 0, 0));
    wr(1, 64'hFFFF_FFFF_FFFF_FFFE);
    ev(1, 0);
    chk("R7 wide no ovf yet", {63'd0, ovf_q}, 0);
    chk("R7 wide passes bit 31", count_q, 64'hFFFF_FFFF_FFFF_FFFF);
    // overflow clear in same cycle as a new carry: carry wins
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 64'd1;
    ev_valid = 1'b1; ev_count = 8'd2; ev_level = 2'd0;
    step();
    wr_en = 1'b0; ev_valid = 1'b0;
    chk("R7 wide wrap", count_q, 1);
    chk("R8 set wins over clear", {63'd0, ovf_q}, 1);
  endtask

  task automatic t_load_prio();
    clean();
    wr(0, mk(1, 1, 0, 0, 0, 0, 0, 0, 0));
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 64'd100;
    ev_valid = 1'b1; ev_count = 8'd5;
    step();
    wr_en = 1'b0; ev_valid = 1'b0;
    chk("R11 load beats increment", count_q, 100);
    wr(3, 64'd7);
    chk("R11 address 3 ignored", count_q, 100);
  endtask

  task automatic t_levels();
    for (int m = 0; m < 5; m++) begin
      bit xu = (m == 0);
      bit xk = (m == 1 || m == 2);
      bit xh = (m == 3 || m == 4);
      bit kh = (m == 2 || m == 4);
      for (int l = 0; l < 4; l++) begin
        bit blk;
        clean();
        wr(0, mk(1, 0, xu, xk, xh, kh, 0, 0, 0));
        ev(1, l);
        if (l == 0) blk = xu;
        else if (l == 1) blk = xk;
        else blk = kh ? xk : xh;
        chk($sformatf("R9 mode %0d level %0d", m, l), count_q, blk ? 0 : 1);
      end
    end
  endtask

  task automatic t_enable();
    clean();
    ev(4, 0);
    chk("R10 disabled", count_q, 0);
    wr(0, mk(1, 0, 0, 0, 0, 0, 0, 0, 0));
    ev_count = 8'd9; ev_valid = 1'b0;
    step();
    chk("R10 invalid sample", count_q, 0);
  endtask

  task automatic t_timing();
    clean();
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = mk(1, 0, 0, 0, 0, 0, 0, 0, 0);
    ev_valid = 1'b1; ev_count = 8'd5;
    step();
    wr_en = 1'b0;
    chk("R12 config not yet active", count_q, 0);
    step();
    ev_valid = 1'b0;
    chk("R12 sample visible after one edge", count_q, 5);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    #0;
    t_reset();
    t_raw();
    t_compare();
    t_cap();
    t_nocap();
    t_wrap();
    t_load_prio();
    t_levels();
    t_enable();
    t_timing();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule